// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block applies the outcome of one bus transaction to a USB transfer descriptor. It takes the descriptor's control/status word, its token word, a result kind and a returned byte count. It returns the rewritten control/status word, two interrupt-cause bits, a transfer-error flag, a process-error flag and a return code. The return code tells the list walker whether the descriptor completed, was skipped or failed, ended short, or was fatally malformed. It also splits the token into PID, device address, endpoint and maximum length. The block does no memory access, no data movement and no scheduling.

One transform is held in a single output register. Input and output each use a valid/ready handshake, and results appear one clock after acceptance. The walker writes `out_ctrl` back to the descriptor. It ORs `out_cause` into the interrupts it has pending for the frame, and it sets the controller's error status from the two flags.

Top module: `td_status_updater`

## Requirements
- R1: The token is decoded as PID = token[7:0], device address = token[14:8], endpoint = token[18:15], and maximum length = (token[31:21] + 1) kept to 11 bits, so 0x7FF decodes to 0. Known PIDs are SETUP 0x2D, IN 0x69 and OUT 0xE1.
- R2: When the active bit (ctrl bit 23) is clear, the control word passes through unchanged. Both causes and both flags are 0 and the return code is SKIP. Return codes are DONE=0, SKIP=1, SHORT=2, FATAL=3.
- R3: A success result (kind 0) writes (len - 1) modulo 2048 into ctrl[10:0] and clears active (bit 23) and NAK (bit 19). It raises cause bit 0 when interrupt-on-complete (bit 24) is set, and returns DONE unless R4 or R5 applies.
- R4: On success with short-packet detect (bit 29) set and len below the maximum length, cause bit 1 is raised and the code is SHORT. When len equals the maximum length, the code stays DONE.
- R5: On success of an IN transfer with len above the maximum length, babble (bit 20) and stalled (bit 22) are set and the transfer-error flag is raised, with code SKIP. Cause bit 0 still follows R3. For OUT and SETUP, an oversize length is not babble. A babble result (kind 2) sets bits 20 and 22, clears active and raises the transfer-error flag.
- R6: A stall result (kind 1) sets stalled, clears active, raises the transfer-error flag and returns SKIP.
- R7: A NAK result (kind 3) for IN or OUT sets NAK (bit 19), leaves active unchanged and returns SKIP with no error.
- R8: A NAK result for a SETUP PID sets NAK and then takes the timeout path of R9.
- R9: A timeout result (kinds 4 to 7) sets timeout (bit 18). If the error counter ctrl[28:27] is nonzero, it is decremented. A decrement that reaches zero clears active, raises the transfer-error flag, and raises cause bit 0 if interrupt-on-complete is set. A counter already at zero stays zero and active stays set.
- R10: When isochronous (bit 25) is set on an active descriptor with a known PID, active is cleared whatever the result.
- R11: An active descriptor with an unknown PID leaves the control word unchanged, raises the process-error flag and returns FATAL.
- R12: in_ready is high when the output register is empty or out_ready is high. An accepted input appears at the outputs on the next clock. While out_valid is high and out_ready is low, every output holds.
- R13: Synchronous reset empties the output register (out_valid low, in_ready high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor and result offered |
| in_ready | output | 1 | Offer accepted this cycle |
| in_ctrl | input | 32 | Descriptor control/status word |
| in_token | input | 32 | Descriptor token word |
| in_kind | input | 3 | Result: 0 success, 1 stall, 2 babble, 3 NAK, 4-7 timeout |
| in_len | input | LEN_W | Bytes moved by the transaction |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result |
| out_ctrl | output | 32 | Updated control/status word |
| out_cause | output | 2 | Bit 0 completion, bit 1 short packet |
| out_xfer_err | output | 1 | Transfer error for controller status |
| out_proc_err | output | 1 | Process error (unknown PID) |
| out_ret | output | 2 | Return code DONE/SKIP/SHORT/FATAL |
| out_pid | output | 8 | Decoded PID |
| out_addr | output | 7 | Decoded device address |
| out_endp | output | 4 | Decoded endpoint |
| out_maxlen | output | 11 | Decoded maximum length |

## Verification
On every cycle, the assertions check several properties. Inactive descriptors and unknown PIDs must come out untouched with the right code, and any transfer error must leave active clear. A short-packet cause must carry the SHORT code, a plain NAK must keep the descriptor active, and a stalled output must hold. The arithmetic is shown only by the bench's scenarios, compared against its own model: the minus-one length field, the maximum-length wrap, and the babble decision by PID. The same holds for the error countdown at each counter value, the SETUP NAK redirect and the isochronous override.

// File: rtl/tdsu_pkg.sv
package tdsu_pkg;

    localparam int CTRL_W    = 32;
    localparam int ALEN_W    = 11;

    // control word bit positions (fixed by the descriptor layout)
    localparam int B_SPD     = 29;
    localparam int B_ERR_HI  = 28;
    localparam int B_ERR_LO  = 27;
    localparam int B_ISO     = 25;
    localparam int B_IOC     = 24;
    localparam int B_ACTIVE  = 23;
    localparam int B_STALL   = 22;
    localparam int B_BABBLE  = 20;
    localparam int B_NAK     = 19;
    localparam int B_TIMEOUT = 18;

    localparam int C_DONE    = 0;
    localparam int C_SHORT   = 1;

    localparam logic [7:0] PID_SETUP = 8'h2D;
    localparam logic [7:0] PID_IN    = 8'h69;
    localparam logic [7:0] PID_OUT   = 8'hE1;

    typedef enum logic [2:0] {
        K_OK      = 3'd0,
        K_STALL   = 3'd1,
        K_BABBLE  = 3'd2,
        K_NAK     = 3'd3,
        K_TIMEOUT = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        RET_DONE  = 2'd0,
        RET_SKIP  = 2'd1,
        RET_SHORT = 2'd2,
        RET_FATAL = 2'd3
    } ret_e;

    typedef struct packed {
        logic [7:0]        pid;
        logic [6:0]        addr;
        logic [3:0]        endp;
        logic [ALEN_W-1:0] maxlen;
    } tok_fields_t;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [1:0]        cause;
        logic              xfer_err;
        logic              proc_err;
        ret_e              ret;
    } td_result_t;

    typedef struct packed {
        td_result_t  res;
        tok_fields_t tok;
    } out_word_t;

    function automatic tok_fields_t split_token(input logic [31:0] t);
        tok_fields_t f;
        f.pid    = t[7:0];
        f.addr   = t[14:8];
        f.endp   = t[18:15];
        f.maxlen = t[31:21] + 11'd1;
        return f;
    endfunction

    function automatic logic pid_known(input logic [7:0] p);
        return (p == PID_SETUP) || (p == PID_IN) || (p == PID_OUT);
    endfunction

endpackage

// File: rtl/tdsu_token_decode.sv
module tdsu_token_decode
    import tdsu_pkg::*;
(
    input  logic [31:0] token_i,
    output tok_fields_t fields_o,
    output logic        known_o
);
    always_comb begin
        fields_o = split_token(token_i);
        known_o  = pid_known(fields_o.pid);
    end
endmodule

// File: rtl/tdsu_status_calc.sv
module tdsu_status_calc
    import tdsu_pkg::*;
#(
    parameter int LEN_W = 12
)(
    input  logic [CTRL_W-1:0] ctrl_i,
    input  tok_fields_t       tok_i,
    input  logic              known_i,
    input  logic [2:0]        kind_i,
    input  logic [LEN_W-1:0]  len_i,
    output td_result_t        res_o
);
    localparam int CMP_W = (LEN_W > ALEN_W) ? LEN_W + 1 : ALEN_W + 1;

    logic [CTRL_W-1:0] c;
    logic [1:0]        cause;
    logic              xe;
    logic              pe;
    ret_e              ret;
    logic              to_path;
    logic [1:0]        cnt;
    logic [ALEN_W-1:0] len_m1;
    logic              over_max;
    logic              under_max;

    always_comb begin
        len_m1    = ALEN_W'(len_i - 1'b1);
        over_max  = CMP_W'(len_i) > CMP_W'(tok_i.maxlen);
        under_max = CMP_W'(len_i) < CMP_W'(tok_i.maxlen);
    end

    always_comb begin
        c       = ctrl_i;
        cause   = '0;
        xe      = 1'b0;
        pe      = 1'b0;
        ret     = RET_SKIP;
        to_path = 1'b0;
        cnt     = '0;
        if (!ctrl_i[B_ACTIVE]) begin
            ret = RET_SKIP;
        end else if (!known_i) begin
            pe  = 1'b1;
            ret = RET_FATAL;
        end else begin
            if (ctrl_i[B_ISO]) c[B_ACTIVE] = 1'b0;
            case (kind_e'(kind_i))
                K_OK: begin
                    c[ALEN_W-1:0] = len_m1;
                    c[B_ACTIVE]   = 1'b0;
                    c[B_NAK]      = 1'b0;
                    if (c[B_IOC]) cause[C_DONE] = 1'b1;
                    if ((tok_i.pid == PID_IN) && over_max) begin
                        c[B_BABBLE] = 1'b1;
                        c[B_STALL]  = 1'b1;
                        xe          = 1'b1;
                        ret         = RET_SKIP;
                    end else if (c[B_SPD] && under_max) begin
                        cause[C_SHORT] = 1'b1;
                        ret            = RET_SHORT;
                    end else begin
                        ret = RET_DONE;
                    end
                end
                K_STALL: begin
                    c[B_STALL]  = 1'b1;
                    c[B_ACTIVE] = 1'b0;
                    xe          = 1'b1;
                end
                K_BABBLE: begin
                    c[B_BABBLE] = 1'b1;
                    c[B_STALL]  = 1'b1;
                    c[B_ACTIVE] = 1'b0;
                    xe          = 1'b1;
                end
                K_NAK: begin
                    c[B_NAK] = 1'b1;
                    to_path  = (tok_i.pid == PID_SETUP);
                end
                default: to_path = 1'b1;
            endcase
            if (to_path) begin
                c[B_TIMEOUT] = 1'b1;
                cnt = c[B_ERR_HI:B_ERR_LO];
                if (cnt != 2'd0) begin
                    cnt = cnt - 2'd1;
                    if (cnt == 2'd0) begin
                        c[B_ACTIVE] = 1'b0;
                        xe          = 1'b1;
                        if (c[B_IOC]) cause[C_DONE] = 1'b1;
                    end
                end
                c[B_ERR_HI:B_ERR_LO] = cnt;
            end
        end
    end

    always_comb begin
        res_o.ctrl     = c;
        res_o.cause    = cause;
        res_o.xfer_err = xe;
        res_o.proc_err = pe;
        res_o.ret      = ret;
    end
endmodule

// File: rtl/tdsu_out_stage.sv
module tdsu_out_stage #(
    parameter int W = 8
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         i_valid,
    output logic         i_ready,
    input  logic [W-1:0] i_data,
    output logic         o_valid,
    input  logic         o_ready,
    output logic [W-1:0] o_data
);
    assign i_ready = !o_valid || o_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            o_data  <= '0;
        end else if (i_ready) begin
            o_valid <= i_valid;
            if (i_valid) o_data <= i_data;
        end
    end

    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        o_valid && !o_ready |=> o_valid && $stable(o_data));

    assert_empty_after_reset_R13: assert property (@(posedge clk)
        rst |=> !o_valid);
endmodule

// File: rtl/td_status_updater.sv
module td_status_updater
    import tdsu_pkg::*;
#(
    parameter int LEN_W = 12
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      in_ctrl,
    input  logic [31:0]      in_token,
    input  logic [2:0]       in_kind,
    input  logic [LEN_W-1:0] in_len,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [31:0]      out_ctrl,
    output logic [1:0]       out_cause,
    output logic             out_xfer_err,
    output logic             out_proc_err,
    output logic [1:0]       out_ret,
    output logic [7:0]       out_pid,
    output logic [6:0]       out_addr,
    output logic [3:0]       out_endp,
    output logic [10:0]      out_maxlen
);
    localparam int OW = $bits(out_word_t);

    tok_fields_t tok;
    logic        known;
    td_result_t  res;
    out_word_t   word_d;
    out_word_t   word_q;
    logic        in_fire;

    tdsu_token_decode u_dec (
        .token_i  (in_token),
        .fields_o (tok),
        .known_o  (known)
    );

    tdsu_status_calc #(.LEN_W(LEN_W)) u_calc (
        .ctrl_i  (in_ctrl),
        .tok_i   (tok),
        .known_i (known),
        .kind_i  (in_kind),
        .len_i   (in_len),
        .res_o   (res)
    );

    assign word_d.res = res;
    assign word_d.tok = tok;

    tdsu_out_stage #(.W(OW)) u_out (
        .clk     (clk),
        .rst     (rst),
        .i_valid (in_valid),
        .i_ready (in_ready),
        .i_data  (word_d),
        .o_valid (out_valid),
        .o_ready (out_ready),
        .o_data  (word_q)
    );

    assign in_fire      = in_valid && in_ready;
    assign out_ctrl     = word_q.res.ctrl;
    assign out_cause    = word_q.res.cause;
    assign out_xfer_err = word_q.res.xfer_err;
    assign out_proc_err = word_q.res.proc_err;
    assign out_ret      = word_q.res.ret;
    assign out_pid      = word_q.tok.pid;
    assign out_addr     = word_q.tok.addr;
    assign out_endp     = word_q.tok.endp;
    assign out_maxlen   = word_q.tok.maxlen;

    assert_skip_inactive_R2: assert property (@(posedge clk) disable iff (rst)
        in_fire && !in_ctrl[B_ACTIVE] |=>
            out_valid && out_ctrl == $past(in_ctrl) && out_ret == 2'd1 &&
            out_cause == 2'b00 && !out_xfer_err && !out_proc_err);

    assert_fatal_pid_R11: assert property (@(posedge clk) disable iff (rst)
        in_fire && in_ctrl[B_ACTIVE] && in_token[7:0] != 8'h2D &&
        in_token[7:0] != 8'h69 && in_token[7:0] != 8'hE1 |=>
            out_proc_err && out_ret == 2'd3 && out_ctrl == $past(in_ctrl));

    // R5 and R6: any transfer error retires the descriptor
    assert_err_retires_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_xfer_err |-> !out_ctrl[B_ACTIVE]);

    assert_short_code_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_cause[C_SHORT] |-> out_ret == 2'd2);

    assert_nak_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        in_fire && in_ctrl[B_ACTIVE] && !in_ctrl[B_ISO] && in_kind == 3'd3 &&
        (in_token[7:0] == 8'h69 || in_token[7:0] == 8'hE1) |=>
            out_ctrl[B_ACTIVE] && out_ctrl[B_NAK] && !out_xfer_err);
endmodule

// File: tb/tb_td_status_updater.sv
module tb_td_status_updater;
    localparam int LEN_W = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [31:0]      in_ctrl = '0;
    logic [31:0]      in_token = '0;
    logic [2:0]       in_kind = '0;
    logic [LEN_W-1:0] in_len = '0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [31:0]      out_ctrl;
    logic [1:0]       out_cause;
    logic             out_xfer_err;
    logic             out_proc_err;
    logic [1:0]       out_ret;
    logic [7:0]       out_pid;
    logic [6:0]       out_addr;
    logic [3:0]       out_endp;
    logic [10:0]      out_maxlen;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    td_status_updater #(.LEN_W(LEN_W)) dut (.*);

    function automatic logic [31:0] mk_tok(logic [7:0] pid, logic [6:0] a,
                                           logic [3:0] e, logic [10:0] mf);
        return {mf, 2'b00, e, a, pid};
    endfunction

    // model: returns ctrl, and side = {cause[1:0], xerr, perr, ret[1:0]}
    function automatic void model(input logic [31:0] ci, input logic [31:0] t,
                                  input logic [2:0] k, input logic [LEN_W-1:0] n,
                                  output logic [31:0] co, output logic [5:0] side);
        logic [7:0] p = t[7:0];
        int mx = (int'(t[31:21]) + 1) % 2048;
        logic [1:0] cs = 0; logic xe = 0, pe = 0; logic [1:0] r = 2'd1;
        bit to = 0; int e;
        co = ci;
        if (ci[23]) begin
            if (p != 8'h2D && p != 8'h69 && p != 8'hE1) begin
                pe = 1; r = 2'd3;
            end else begin
                if (ci[25]) co[23] = 0;
                if (k == 0) begin
                    co[10:0] = 11'((int'(n) + 2047) % 2048);
                    co[23] = 0; co[19] = 0;
                    if (co[24]) cs[0] = 1;
                    if (p == 8'h69 && int'(n) > mx) begin
                        co[20] = 1; co[22] = 1; xe = 1;
                    end else if (co[29] && int'(n) < mx) begin
                        cs[1] = 1; r = 2'd2;
                    end else r = 2'd0;
                end else if (k == 1) begin
                    co[22] = 1; co[23] = 0; xe = 1;
                end else if (k == 2) begin
                    co[20] = 1; co[22] = 1; co[23] = 0; xe = 1;
                end else if (k == 3) begin
                    co[19] = 1; to = (p == 8'h2D);
                end else to = 1;
                if (to) begin
                    co[18] = 1; e = int'(co[28:27]);
                    if (e > 0) begin
                        e = e - 1;
                        if (e == 0) begin co[23] = 0; xe = 1; if (co[24]) cs[0] = 1; end
                    end
                    co[28:27] = 2'(e);
                end
            end
        end
        side = {cs, xe, pe, r};
    endfunction

    task automatic check(string req, string what, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_out(string req, logic [31:0] ci, logic [31:0] t,
                             logic [2:0] k, logic [LEN_W-1:0] n);
        logic [31:0] ec; logic [5:0] es;
        model(ci, t, k, n, ec, es);
        check(req, "valid", 64'(out_valid), 64'd1);
        check(req, "ctrl", 64'(out_ctrl), 64'(ec));
        check(req, "flags", 64'({out_cause, out_xfer_err, out_proc_err, out_ret}), 64'(es));
        check("R1", "token", 64'({out_pid, out_addr, out_endp, out_maxlen}),
              64'({t[7:0], t[14:8], t[18:15], 11'(t[31:21] + 11'd1)}));
    endtask

    task automatic run(string req, logic [31:0] ci, logic [31:0] t,
                       logic [2:0] k, logic [LEN_W-1:0] n);
        @(negedge clk);
        in_ctrl = ci; in_token = t; in_kind = k; in_len = n; in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        check_out(req, ci, t, k, n);
    endtask

    localparam logic [31:0] ACT = 32'h0080_0000;
    localparam logic [31:0] IOC = 32'h0100_0000;
    localparam logic [31:0] SPD = 32'h2000_0000;
    localparam logic [31:0] ISO = 32'h0200_0000;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] ta, tb;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        // R13 reset state
        check("R13", "out_valid", 64'(out_valid), 64'd0);
        check("R13", "in_ready", 64'(in_ready), 64'd1);

        run("R1",  ACT, mk_tok(8'h69, 7'h55, 4'hA, 11'd7), 3'd0, 12'd8);
        run("R1",  ACT, mk_tok(8'h69, 7'h01, 4'h1, 11'h7FF), 3'd0, 12'd1);
        run("R2",  32'h1234_5677 & ~ACT, mk_tok(8'h69, 7'h2, 4'h0, 11'd7), 3'd1, 12'd3);
        run("R3",  ACT | IOC | 32'h19, mk_tok(8'h69, 7'h3, 4'h2, 11'd7), 3'd0, 12'd8);
        run("R3",  ACT | 32'h0008_0000, mk_tok(8'hE1, 7'h3, 4'h2, 11'd7), 3'd0, 12'd0);
        run("R4",  ACT | SPD | IOC, mk_tok(8'h69, 7'h4, 4'h1, 11'd7), 3'd0, 12'd3);
        run("R4",  ACT | SPD, mk_tok(8'h69, 7'h4, 4'h1, 11'd7), 3'd0, 12'd8);
        run("R5",  ACT | IOC, mk_tok(8'h69, 7'h5, 4'h1, 11'd7), 3'd0, 12'd9);
        run("R5",  ACT, mk_tok(8'hE1, 7'h5, 4'h1, 11'd7), 3'd0, 12'd9);
        run("R5",  ACT, mk_tok(8'h69, 7'h5, 4'h1, 11'd7), 3'd2, 12'd9);
        run("R6",  ACT | 32'h1800_0000, mk_tok(8'hE1, 7'h6, 4'h3, 11'd63), 3'd1, 12'd0);
        run("R7",  ACT | 32'h1000_0000, mk_tok(8'h69, 7'h7, 4'h3, 11'd63), 3'd3, 12'd0);
        run("R8",  ACT | IOC | 32'h0800_0000, mk_tok(8'h2D, 7'h8, 4'h0, 11'd7), 3'd3, 12'd8);
        run("R9",  ACT | 32'h1800_0000, mk_tok(8'hE1, 7'h9, 4'h0, 11'd7), 3'd4, 12'd0);
        run("R9",  ACT | IOC | 32'h0800_0000, mk_tok(8'h69, 7'h9, 4'h0, 11'd7), 3'd7, 12'd0);
        run("R9",  ACT | IOC, mk_tok(8'h69, 7'h9, 4'h0, 11'd7), 3'd4, 12'd0);
        run("R10", ACT | ISO, mk_tok(8'h69, 7'hA, 4'h0, 11'd7), 3'd3, 12'd0);
        run("R10", ACT | ISO | 32'h1800_0000, mk_tok(8'hE1, 7'hA, 4'h0, 11'd7), 3'd4, 12'd0);
        run("R11", ACT | 32'h0000_0042, mk_tok(8'h4B, 7'hB, 4'h0, 11'd7), 3'd0, 12'd4);

        // R12 backpressure: result holds, input waits
        ta = mk_tok(8'h69, 7'h21, 4'h5, 11'd15);
        tb = mk_tok(8'hE1, 7'h22, 4'h6, 11'd15);
        @(negedge clk);
        out_ready = 0;
        in_ctrl = ACT | IOC; in_token = ta; in_kind = 3'd0; in_len = 12'd16; in_valid = 1;
        @(negedge clk);
        check("R12", "in_ready stalled", 64'(in_ready), 64'd0);
        in_ctrl = ACT; in_token = tb; in_kind = 3'd1; in_len = 12'd2;
        @(negedge clk);
        check_out("R12", ACT | IOC, ta, 3'd0, 12'd16);
        out_ready = 1;
        @(negedge clk);
        in_valid = 0;
        check_out("R12", ACT, tb, 3'd1, 12'd2);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] c, t; logic [7:0] p; logic [10:0] mf; logic [2:0] k;
            logic [LEN_W-1:0] n; string rq;
            c = $urandom();
            c[23] = ($urandom_range(0, 9) != 0);
            case ($urandom_range(0, 3))
                0: p = 8'h2D; 1: p = 8'h69; 2: p = 8'hE1; default: p = 8'($urandom());
            endcase
            mf = ($urandom_range(0, 7) == 0) ? 11'h7FF : 11'($urandom_range(0, 15));
            t = mk_tok(p, 7'($urandom()), 4'($urandom()), mf);
            t[20:19] = 2'($urandom());
            k = 3'($urandom());
            n = LEN_W'($urandom_range(0, 19));
            if (!c[23]) rq = "R2";
            else if (p != 8'h2D && p != 8'h69 && p != 8'hE1) rq = "R11";
            else if (c[25]) rq = "R10";
            else if (k == 0) rq = "R3";
            else if (k == 1) rq = "R6";
            else if (k == 2) rq = "R5";
            else if (k == 3) rq = (p == 8'h2D) ? "R8" : "R7";
            else rq = "R9";
            run(rq, c, t, k, n);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule